// File: doc/BRIEF.md
# Carry-Skip Adder with Configurable Block Sizes

This block adds two unsigned operands and a carry-in in a single combinational pass. It returns the sum and a carry-out. The operand width is split into consecutive ripple-carry segments. Each segment checks whether every one of its bit positions would pass an incoming carry straight through. When that is true, a bypass multiplexer hands the segment's carry-in directly to its carry-out, so the long ripple through that segment is removed from the carry path.

Segment sizes come from a packed parameter list, and neighbouring segments may differ in size. The usual arrangement is short segments at both ends and longer ones in the middle, which makes the worst carry path shorter than uniform sizing does. The segment sums are always formed by the ripple chain, fed by the segment's true carry-in. The bypass only accelerates the carry that goes on to the next segment. There is no clock, no handshake and no state: results follow the inputs after the logic settles.

Top module: `carry_skip_adder`

## Requirements
- R1: For every input, {carry_out, sum_o} equals op_a + op_b + carry_in, computed at WIDTH+1 bits.
- R2: The segment list SEG_SIZES holds one 8-bit field per segment. Field k is bits [8k+7:8k] and gives the size of segment k. Segment 0 holds the least significant bits, and each later segment starts where the previous one ended. The fields must sum to WIDTH. The default is four segments of 4 bits over a 16-bit width.
- R3: Bit k propagates when op_a[k] XOR op_b[k] is 1. A segment is bypassed exactly when all of its bits propagate. Every sum bit of a bypassed segment then equals the inverse of that segment's carry-in.
- R4: In a bypassed segment, the carry-out equals the carry-in, so a carry-in of 1 across an all-propagate operand pair reaches carry_out.
- R5: In a segment that is not bypassed, the carry-out depends only on that segment's own operand bits. It equals the carry of the segment's op_a plus op_b with a zero carry-in.
- R6: The sum bits of each segment equal that segment's op_a plus op_b plus its actual carry-in, truncated to the segment width.
- R7: carry_out is the carry-out of the last (most significant) segment.
- R8: A non-uniform size list, such as 1, 3, 5, 4 and 3 bits from the least significant end, gives the same results as the uniform default for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the most significant segment |

## Verification
The hardest case to reach from the ports is a carry that must travel through several bypassed segments in a row. A close second is a segment that sits one bit short of full propagation, where a single killing or generating bit must stop the bypass. Random operands almost never produce either case. The stimulus therefore builds them on purpose. Complementary operands with a carry-in of 1 force every segment into bypass. A walking pattern then clears one propagate bit at a time, so that each segment in turn drops out of bypass at each of its positions. Both a uniform and a non-uniform instance receive the same stimulus.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned FIELD_W    = 8;
  localparam int unsigned MAX_SEGS   = 32;
  localparam int unsigned LIST_W     = FIELD_W * MAX_SEGS;

  function automatic int unsigned seg_size(input logic [LIST_W-1:0] list,
                                           input int unsigned k);
    return {24'b0, list[k*FIELD_W +: FIELD_W]};
  endfunction

  function automatic int unsigned seg_offset(input logic [LIST_W-1:0] list,
                                             input int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < k; i++) acc += seg_size(list, i);
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple_seg.sv
module csa_ripple_seg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] s,
  output logic         c_rip,
  output logic         all_prop
);
  logic [W:0]   chain;
  logic [W-1:0] prop;

  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic gen;
    assign prop[i]      = a[i] ^ b[i];
    assign gen          = a[i] & b[i];
    assign s[i]         = prop[i] ^ chain[i];
    assign chain[i+1]   = gen | (prop[i] & chain[i]);
  end

  assign c_rip    = chain[W];
  assign all_prop = &prop;
endmodule

// File: rtl/csa_bypass_mux.sv
module csa_bypass_mux (
  input  logic skip,
  input  logic c_seg_in,
  input  logic c_ripple,
  output logic c_seg_out
);
  always_comb begin
    if (skip) c_seg_out = c_seg_in;
    else      c_seg_out = c_ripple;
  end
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int unsigned WIDTH     = 16,
  parameter int unsigned NUM_SEGS  = 4,
  parameter logic [NUM_SEGS*8-1:0] SEG_SIZES = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_out
);
  localparam logic [csa_pkg::LIST_W-1:0] LIST_EXT =
    csa_pkg::LIST_W'(SEG_SIZES);

  logic [NUM_SEGS:0]   seg_carry;
  logic [NUM_SEGS-1:0] seg_skip;

  assign seg_carry[0] = carry_in;

  for (genvar k = 0; k < NUM_SEGS; k++) begin : g_seg
    localparam int unsigned OFF = csa_pkg::seg_offset(LIST_EXT, k);
    localparam int unsigned SW  = csa_pkg::seg_size(LIST_EXT, k);
    logic c_rip;

    csa_ripple_seg #(.W(SW)) u_rip (
      .a        (op_a[OFF +: SW]),
      .b        (op_b[OFF +: SW]),
      .c_in     (seg_carry[k]),
      .s        (sum_o[OFF +: SW]),
      .c_rip    (c_rip),
      .all_prop (seg_skip[k])
    );

    csa_bypass_mux u_mux (
      .skip      (seg_skip[k]),
      .c_seg_in  (seg_carry[k]),
      .c_ripple  (c_rip),
      .c_seg_out (seg_carry[k+1])
    );
  end

  assign carry_out = seg_carry[NUM_SEGS];
endmodule

// File: rtl/csa_checker.sv
module csa_checker #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned NUM_SEGS = 4,
  parameter logic [NUM_SEGS*8-1:0] SEG_SIZES = {8'd4, 8'd4, 8'd4, 8'd4}
) (
  input logic [WIDTH-1:0]    op_a,
  input logic [WIDTH-1:0]    op_b,
  input logic                carry_in,
  input logic [WIDTH-1:0]    sum_o,
  input logic                carry_out,
  input logic [NUM_SEGS:0]   seg_carry,
  input logic [NUM_SEGS-1:0] seg_skip
);
  localparam logic [csa_pkg::LIST_W-1:0] LIST_EXT =
    csa_pkg::LIST_W'(SEG_SIZES);

  always_comb begin
    AST_TOTAL_SUM: assert ({carry_out, sum_o} ==
                           ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
      else $error("total sum mismatch");  // R1
  end

  for (genvar k = 0; k < NUM_SEGS; k++) begin : g_chk
    localparam int unsigned OFF = csa_pkg::seg_offset(LIST_EXT, k);
    localparam int unsigned SW  = csa_pkg::seg_size(LIST_EXT, k);
    logic [SW:0] local_add;
    logic [SW:0] full_add;

    always_comb begin
      local_add = {1'b0, op_a[OFF +: SW]} + {1'b0, op_b[OFF +: SW]};
      full_add  = local_add + {{SW{1'b0}}, seg_carry[k]};
      AST_SKIP_SUM: assert (!seg_skip[k] || (sum_o[OFF +: SW] == {SW{~seg_carry[k]}}))
        else $error("bypassed segment sum wrong");  // R3
      AST_SKIP_PASS: assert (!seg_skip[k] || (seg_carry[k+1] == seg_carry[k]))
        else $error("bypass did not forward carry");  // R4
      AST_LOCAL_CARRY: assert (seg_skip[k] || (seg_carry[k+1] == local_add[SW]))
        else $error("unbypassed carry depends on carry-in");  // R5
      AST_SEG_SUM: assert (sum_o[OFF +: SW] == full_add[SW-1:0])
        else $error("segment sum wrong");  // R6
    end
  end
endmodule

bind carry_skip_adder csa_checker #(
  .WIDTH(WIDTH), .NUM_SEGS(NUM_SEGS), .SEG_SIZES(SEG_SIZES)
) u_csa_chk (
  .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
  .sum_o(sum_o), .carry_out(carry_out),
  .seg_carry(seg_carry), .seg_skip(seg_skip)
);

// File: tb/carry_skip_adder_bench.sv
`timescale 1ns/1ps
module carry_skip_adder_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b;
  logic         ci;
  logic [W-1:0] sum_u, sum_v;
  logic         co_u, co_v;

  carry_skip_adder u_carry_skip_adder (
    .op_a(a), .op_b(b), .carry_in(ci), .sum_o(sum_u), .carry_out(co_u));

  carry_skip_adder #(
    .WIDTH(16), .NUM_SEGS(5), .SEG_SIZES({8'd3, 8'd4, 8'd5, 8'd3, 8'd1})
  ) u_carry_skip_adder_var (
    .op_a(a), .op_b(b), .carry_in(ci), .sum_o(sum_v), .carry_out(co_v));

  logic [W:0] exp_q[$];
  string      tag_q[$];
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic xc, input string tag);
    @(posedge clk);
    #1;
    a = xa; b = xb; ci = xc;
    exp_q.push_back({1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, xc});
    tag_q.push_back(tag);
  endtask

  task automatic check(input logic [W:0] got, input logic [W:0] exp,
                       input string tag, input string which);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s instance): got %h expected %h", tag, which, got, exp);
    end
  endtask

  // scoreboard monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [W:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({co_u, sum_u}, e, t, "uniform");
      check({co_v, sum_v}, e, t, "variable R8");
    end
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // quiescent state: zero inputs give zero outputs
    drive(16'h0000, 16'h0000, 1'b0, "R1 idle");
    // all segments bypassed, carry travels end to end
    drive(16'hFFFF, 16'h0000, 1'b1, "R4 full bypass");
    drive(16'h5555, 16'hAAAA, 1'b1, "R4 complement");
    drive(16'h5555, 16'hAAAA, 1'b0, "R3 bypass no carry");
    drive(16'h0F0F, 16'hF0F0, 1'b1, "R7 carry out via bypass");
    drive(16'h8000, 16'h8000, 1'b0, "R7 msb generate");
    drive(16'h1234, 16'h4321, 1'b0, "R1 plain");
    drive(16'h00F0, 16'h0010, 1'b0, "R5 local generate");
    drive(16'h0000, 16'h0000, 1'b1, "R5 kill carry-in");
    drive(16'h7FFF, 16'h0001, 1'b0, "R6 long ripple");
    // R2 segment boundaries: a single killing bit walks across every position
    for (int i = 0; i < W; i++)
      drive(16'hFFFF ^ (16'h1 << i), 16'h0000, 1'b1, "R5 walking kill");
    // R3 walking generate inside otherwise propagating operands
    for (int i = 0; i < W; i++)
      drive(16'hFFFF, 16'h1 << i, 1'b1, "R6 walking generate");
    for (int i = 0; i < 200; i++)
      drive(16'($urandom()), 16'($urandom()), 1'($urandom()), "R1 random");
    repeat (4) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule